// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control core of a successive-approximation converter. A falling edge on the convert-start input begins a conversion. From that point the block raises its busy flag. It steps a trial register from the most significant bit down to the least significant bit, one bit per rising edge of a gated conversion clock. At each step it keeps or rejects the bit under trial according to a comparator input. The trial register drives an external DAC through `dac_code`, which is in true form. The result is presented on `data_out` in complementary, negative-true form.

The number of bits to resolve is chosen per conversion. The block can stop after any bit from 1 to the full width, and bits below the chosen resolution keep their preset value. A coding input turns the complementary offset binary result into complementary twos complement by inverting the top output bit. The block advances one step every two system clocks, so the conversion clock runs at half the system clock while busy and stays low while idle.

Top module: `sar_sequencer`

## Requirements
- R1: After reset, `busy` and `conv_clk` are 0 and `data_out` is all ones.
- R2: A conversion starts at the first clock edge that samples `conv_start` low after an edge that sampled it high. `busy` is high after that edge.
- R3: At the start, the trial register is set with its MSB cleared and all other bits set. `data_out` then reads 0x7FFF and `dac_code` reads 0x8000 (for WIDTH 16, `ctc_mode` low).
- R4: At step k (k = 1..N), bit k counted from the MSB is decided, and bit k+1 is cleared in the same step if k < N. A high `cmp_keep` keeps the trial, so the `data_out` bit is 0. A low `cmp_keep` rejects it, so the `data_out` bit is 1.
- R5: The resolution N is taken from `res_sel` at the start and held for the whole conversion. A value of 0 or above WIDTH means WIDTH. `busy` stays high for exactly 2N+1 clock cycles.
- R6: In a conversion of N bits, the WIDTH−N low bits of `data_out` remain 1.
- R7: `conv_clk` shows exactly N+1 rising edges per conversion and is 0 whenever `busy` is 0.
- R8: `data_out` changes only in a cycle where `conv_clk` rises. The final result is present for at least one cycle before `busy` falls.
- R9: When `ctc_mode` is high, only the MSB of `data_out` is inverted. The stored result is unchanged, so the value returns when `ctc_mode` drops.
- R10: A start edge seen while `busy` is high, including in the last busy cycle, is ignored and does not disturb the conversion in progress.
- R11: For an ideal comparator, the final `data_out` equals the bitwise complement of the input code truncated to N bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_start | input | 1 | Convert command; its falling edge starts a conversion |
| cmp_keep | input | 1 | Comparator: 1 when the input is at or above the DAC trial |
| res_sel | input | RW | Bits to resolve (0 or above WIDTH means WIDTH) |
| ctc_mode | input | 1 | 1 inverts the output MSB (twos-complement coding) |
| dac_code | output | WIDTH | True-form trial word for the DAC |
| data_out | output | WIDTH | Complementary result word |
| busy | output | 1 | High during a conversion |
| conv_clk | output | 1 | Gated conversion clock, low while idle |

## Verification
The assertions assume that `cmp_keep` settles within one system clock of a `dac_code` change. The bench guarantees this by driving `cmp_keep` as a combinational compare of a held analog code against `dac_code`. The assertions also assume that a start pulse spans at least one sampling edge high and then stays low long enough for its edge to be seen. The bench holds `conv_start` for whole clock cycles, changing it only on falling clock edges. During some conversions the bench deliberately inserts extra start pulses and changes `res_sel`, so that the ignore and capture rules are exercised.

// File: rtl/sar_sequencer.sv
module sar_sequencer #(
  parameter int WIDTH = 16,
  parameter int RW = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_start,
  input  logic             cmp_keep,
  input  logic [RW-1:0]    res_sel,
  input  logic             ctc_mode,
  output logic [WIDTH-1:0] dac_code,
  output logic [WIDTH-1:0] data_out,
  output logic             busy,
  output logic             conv_clk
);

  localparam logic [WIDTH-1:0] INIT = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic [RW-1:0]    FULL = RW'(WIDTH);

  logic             start_q, busy_q, clk_q, last_q;
  logic [WIDTH-1:0] sar_q, sar_nx;
  logic [RW-1:0]    step_q, nbits_q, res_eff, step_nx;
  logic             fall;

  assign fall    = start_q & ~conv_start;
  assign res_eff = (res_sel == '0 || res_sel > FULL) ? FULL : res_sel;
  assign step_nx = step_q + RW'(1);

  always_comb begin
    sar_nx = sar_q;
    for (int i = 0; i < WIDTH; i++) begin
      if (i == WIDTH - int'(step_nx)) sar_nx[i] = ~cmp_keep;
      if (i == WIDTH - 1 - int'(step_nx) && step_nx < nbits_q) sar_nx[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      busy_q  <= 1'b0;
      clk_q   <= 1'b0;
      last_q  <= 1'b0;
      sar_q   <= '1;
      step_q  <= '0;
      nbits_q <= FULL;
    end else begin
      start_q <= conv_start;
      if (!busy_q) begin
        if (fall) begin
          busy_q  <= 1'b1;
          clk_q   <= 1'b1;
          sar_q   <= INIT;
          step_q  <= '0;
          nbits_q <= res_eff;
          last_q  <= 1'b0;
        end
      end else if (last_q) begin
        busy_q <= 1'b0;
        clk_q  <= 1'b0;
        last_q <= 1'b0;
      end else if (clk_q) begin
        clk_q <= 1'b0;
      end else begin
        clk_q  <= 1'b1;
        sar_q  <= sar_nx;
        step_q <= step_nx;
        if (step_nx == nbits_q) last_q <= 1'b1;
      end
    end
  end

  assign dac_code = ~sar_q;
  assign data_out = sar_q ^ {ctc_mode, {(WIDTH-1){1'b0}}};
  assign busy     = busy_q;
  assign conv_clk = clk_q;

  a_r7_clk_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !clk_q);

  a_r8_data_on_clk_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sar_q) |-> $rose(clk_q));

  a_r3_init_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> sar_q == INIT);

  a_r5_stop_at_n: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> step_q == nbits_q);

  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !last_q |=> busy_q && $stable(nbits_q));

endmodule

// File: tb/sar_sequencer_test.sv
module sar_sequencer_test;
  localparam int W = 16;
  localparam int RW = 5;

  logic clk = 0, rst_n = 0, conv_start = 0, ctc_mode = 0;
  logic [RW-1:0] res_sel = '0;
  logic [W-1:0] ain = '0;
  logic [W-1:0] dac_code, data_out;
  logic busy, conv_clk, cmp_keep;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;
  assign cmp_keep = (ain >= dac_code);

  sar_sequencer #(.WIDTH(W), .RW(RW)) uut (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .cmp_keep(cmp_keep),
    .res_sel(res_sel), .ctc_mode(ctc_mode), .dac_code(dac_code),
    .data_out(data_out), .busy(busy), .conv_clk(conv_clk));

  function automatic int eff_n(input int n);
    return (n == 0 || n > W) ? W : n;
  endfunction

  function automatic logic [W-1:0] exp_word(input logic [W-1:0] a, input int n, input logic ctc);
    logic [W-1:0] t;
    t = ~((a >> (W - n)) << (W - n));
    return t ^ {ctc, {(W-1){1'b0}}};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic convert(input logic [W-1:0] a, input int n, input logic ctc, input bit disturb);
    int ne, bcyc, rises, bad_change, finalok;
    logic prev_clk, prev_seen;
    logic [W-1:0] prev_data, expw;
    ne = eff_n(n);
    expw = exp_word(a, ne, ctc);
    @(negedge clk);
    ain = a; res_sel = RW'(n); ctc_mode = ctc; conv_start = 1;
    @(negedge clk);
    conv_start = 0;
    @(negedge clk);
    chk("R2 busy after start", busy, 1);
    chk("R3 init data", data_out, 32'h7FFF ^ {ctc, 15'b0});
    chk("R3 init dac", dac_code, 32'h8000);
    bcyc = 0; rises = 1; bad_change = 0; finalok = 0;
    prev_clk = conv_clk; prev_data = data_out; prev_seen = 1;
    while (busy && bcyc < 200) begin
      bcyc++;
      if (data_out === expw) finalok = 1;
      if (disturb && bcyc == 3) begin conv_start = 1; res_sel = RW'($urandom % 32); end
      if (disturb && bcyc == 4) conv_start = 0;
      if (disturb && bcyc == 2 * ne) conv_start = 1;
      if (disturb && bcyc == 2 * ne + 1) conv_start = 0;
      @(negedge clk);
      if (busy || conv_clk) begin
        if (conv_clk && !prev_clk) rises++;
        if (data_out !== prev_data && !(conv_clk && !prev_clk)) bad_change++;
      end
      prev_clk = conv_clk; prev_data = data_out;
    end
    chk("R5 busy length", bcyc, 2 * ne + 1);
    chk("R7 clock rises", rises, ne + 1);
    chk("R7 clock low idle", conv_clk, 0);
    chk("R8 data only on clock rise", bad_change, 0);
    chk("R8 final valid before busy falls", finalok, 1);
    chk("R11 R4 R6 result", data_out, expw);
    if (disturb) begin
      @(negedge clk);
      chk("R10 no restart after ignored edge", busy, 0);
    end
  endtask

  initial begin
    repeat (100000) @(negedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    conv_start = 1;
    @(negedge clk);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset clock", conv_clk, 0);
    chk("R1 reset data", data_out, 32'hFFFF);
    rst_n = 1; conv_start = 0;
    @(negedge clk);
    chk("R2 no start from reset level", busy, 0);

    convert(16'h9185, 16, 0, 0);
    convert(16'h0000, 16, 0, 0);
    convert(16'hFFFF, 16, 0, 0);
    convert(16'h8000, 16, 1, 0);
    convert(16'hABCD, 8, 0, 0);
    convert(16'hABCD, 10, 0, 0);
    convert(16'hABCD, 12, 0, 0);
    convert(16'h1357, 13, 0, 0);
    convert(16'h1357, 14, 1, 0);
    convert(16'hFFFF, 15, 0, 0);
    convert(16'hC000, 1, 0, 0);
    convert(16'h4321, 0, 0, 0);
    convert(16'h4321, 20, 0, 0);
    convert(16'h7E5A, 9, 0, 1);

    @(negedge clk);
    ctc_mode = 1;
    @(negedge clk);
    chk("R9 ctc inverts msb only", data_out, {1'b0, exp_word(16'h7E5A, 9, 0)} ^ 32'h8000);
    ctc_mode = 0;
    @(negedge clk);
    chk("R9 stored value kept", data_out, exp_word(16'h7E5A, 9, 0));

    for (int i = 0; i < 40; i++)
      convert(W'($urandom), int'($urandom % 18), 1'($urandom), 1'($urandom));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule